// File: doc/BRIEF.md
# Conditional-Invert Line-Code Word Decoder

This block sits behind a deserializer that has already found word boundaries. Each clock it may accept one 20-bit line-code word. The word holds a 16-bit word field and a 4-bit coding field. The block decides whether the word carries data, control, idle or nothing legal. On the transmit side the word field may have been inverted, and the block restores it. For control words it packs the 14 useful payload bits onto the low output bits.

Every result is registered and appears one clock after the word, marked by an output strobe. A mode input selects between plain 16-bit data payloads and 17-bit payloads. In 17-bit mode the extra bit is carried by the choice between two families of data coding patterns.

Bit layout of `in_word`: bits 15..0 are word-field bits w0..w15, with wN at bit N. Bits 19..16 are the coding field, and coding values below are written as `in_word[19:16]`.

Top module: `lcw_decoder`

## Requirements
- R1: Each word presented with `in_valid` high produces exactly one result with `out_valid` high on the following clock edge. Results keep the order of the words.
- R2: Coding value 4'b1101 is a true data word. `out_data` is 1 and `out_payload[15:0]` equals the word field.
- R3: Coding value 4'b0010 is an inverted data word. `out_data` is 1 and `out_payload[15:0]` equals the bitwise inverse of the word field.
- R4: Coding value 4'b0011 with w7 different from w8 is a control word. `out_ctrl` is 1, `out_payload[6:0]` = w6..w0, `out_payload[13:7]` = w15..w9, and `out_payload[16:14]` = 0.
- R5: Coding value 4'b1100 with w7 different from w8 is an inverted control word. The word field is inverted first and then packed as in R4.
- R6: Coding value 4'b0011 or 4'b1100 with w7 equal to w8 is idle. `out_valid` is 1, while `out_data`, `out_ctrl`, `out_err` and `out_payload` are all 0.
- R7: With `ext_mode` high, coding values 4'b1011 (true) and 4'b0100 (inverted) are data words with `out_payload[16]` = 1. Values 4'b1101 and 4'b0010 give `out_payload[16]` = 0. With `ext_mode` low, `out_payload[16]` is always 0.
- R8: Every other coding value, and 4'b1011 or 4'b0100 while `ext_mode` is low, raises `out_err`. In that case `out_data` and `out_ctrl` are 0 and `out_payload` is 0.
- R9: At most one of `out_data`, `out_ctrl` and `out_err` is high. A cycle with `in_valid` low gives `out_valid`, all flags and the payload at 0 on the next edge.
- R10: While `rst_n` is low at a clock edge, all outputs are 0 after that edge, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Word on `in_word` is present |
| in_word | input | 20 | Coding field [19:16], word field [15:0] |
| ext_mode | input | 1 | 1 selects 17-bit data payloads |
| out_valid | output | 1 | Result strobe |
| out_data | output | 1 | Data word decoded |
| out_ctrl | output | 1 | Control word decoded |
| out_err | output | 1 | Illegal word |
| out_payload | output | 17 | Restored payload |

## Verification
Every result is due exactly one clock edge after its word is sampled, because the block has a single register stage. The driver changes inputs on the falling edge and pushes the expected result into a queue at that moment. The monitor samples on each later falling edge, so it sees the result of the word captured on the rising edge in between. It pops and compares whenever `out_valid` is high. It also checks that the outputs are zero on cycles with no result, and that the queue is empty once the inputs go quiet.

// File: rtl/lcw_pkg.sv
// Package: shared widths, coding-field values and word kinds for the
// line-code word decoder. Assumes a 4-bit coding field above a word field.
package lcw_pkg;
    localparam int WF_W   = 16;
    localparam int CF_W   = 4;
    localparam int WORD_W = WF_W + CF_W;
    localparam int OUT_W  = WF_W + 1;
    localparam int CTRL_W = WF_W - 2;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_DATA = 2'd1,
        K_CTRL = 2'd2,
        K_ERR  = 2'd3
    } kind_t;

    localparam logic [CF_W-1:0] CF_DATA_T  = 4'b1101;
    localparam logic [CF_W-1:0] CF_DATA_I  = 4'b0010;
    localparam logic [CF_W-1:0] CF_XDATA_T = 4'b1011;
    localparam logic [CF_W-1:0] CF_XDATA_I = 4'b0100;
    localparam logic [CF_W-1:0] CF_CTL_T   = 4'b0011;
    localparam logic [CF_W-1:0] CF_CTL_I   = 4'b1100;
endpackage

// File: rtl/lcw_classify.sv
// Module: lcw_classify
// Decides the kind of a word from its coding field and the two centre bits
// of its word field. Also tells whether the field was inverted on transmit,
// and gives the extra data bit used in 17-bit mode. Purely combinational.
// Assumes the centre bits are taken from the word field as received.
module lcw_classify
    import lcw_pkg::*;
(
    input  logic [CF_W-1:0] cf,
    input  logic [1:0]      centre,
    input  logic            ext_mode,
    output kind_t           kind,
    output logic            invert,
    output logic            xbit
);
    logic centre_differs;

    // Centre bits differ on a control word and match on an idle word.
    assign centre_differs = centre[0] ^ centre[1];

    // Map each coding value to a kind, the inversion flag and the extra bit.
    always_comb begin
        kind   = K_ERR;
        invert = 1'b0;
        xbit   = 1'b0;
        case (cf)
            CF_DATA_T: kind = K_DATA;
            CF_DATA_I: begin
                kind   = K_DATA;
                invert = 1'b1;
            end
            CF_XDATA_T: if (ext_mode) begin
                kind = K_DATA;
                xbit = 1'b1;
            end
            CF_XDATA_I: if (ext_mode) begin
                kind   = K_DATA;
                invert = 1'b1;
                xbit   = 1'b1;
            end
            CF_CTL_T: kind = centre_differs ? K_CTRL : K_IDLE;
            CF_CTL_I: begin
                kind   = centre_differs ? K_CTRL : K_IDLE;
                invert = 1'b1;
            end
            default: kind = K_ERR;
        endcase
    end
endmodule

// File: rtl/lcw_restore.sv
// Module: lcw_restore
// Undoes the transmit-side inversion of the word field. Data words are
// passed whole, with the extra bit on top. Control words lose their two
// centre bits, and the bits above them move down to close the gap.
// Idle and illegal words give zero. Purely combinational.
module lcw_restore
    import lcw_pkg::*;
#(
    parameter int W = WF_W
) (
    input  logic [W-1:0] wf,
    input  kind_t        kind,
    input  logic         invert,
    input  logic         xbit,
    output logic [W:0]   payload
);
    localparam int HALF = W / 2;
    localparam int CW   = W - 2;

    logic [W-1:0]  wf_fix;
    logic [CW-1:0] ctrl;

    // Restore the true polarity of the word field.
    assign wf_fix = invert ? ~wf : wf;

    // Pack the control payload: skip centre bits HALF-1 and HALF.
    for (genvar i = 0; i < CW; i++) begin : g_pack
        if (i < HALF - 1) begin : g_lo
            assign ctrl[i] = wf_fix[i];
        end else begin : g_hi
            assign ctrl[i] = wf_fix[i + 2];
        end
    end

    // Select the payload shape for the decoded kind.
    always_comb begin
        case (kind)
            K_DATA:  payload = {xbit, wf_fix};
            K_CTRL:  payload = {{(W + 1 - CW){1'b0}}, ctrl};
            default: payload = '0;
        endcase
    end
endmodule

// File: rtl/lcw_decoder.sv
// Module: lcw_decoder (top)
// Decodes one aligned conditional-invert line-code word per clock into
// data/control/error flags and a restored payload. All results are
// registered and come one cycle later with out_valid. Assumes word
// alignment is done upstream. Synchronous active-low reset.
module lcw_decoder
    import lcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              ext_mode,
    output logic              out_valid,
    output logic              out_data,
    output logic              out_ctrl,
    output logic              out_err,
    output logic [OUT_W-1:0]  out_payload
);
    localparam int HALF = WF_W / 2;

    kind_t            kind;
    logic             invert;
    logic             xbit;
    logic [OUT_W-1:0] payload;

    lcw_classify u_cls (
        .cf       (in_word[WORD_W-1:WF_W]),
        .centre   (in_word[HALF:HALF-1]),
        .ext_mode (ext_mode),
        .kind     (kind),
        .invert   (invert),
        .xbit     (xbit)
    );

    lcw_restore #(.W(WF_W)) u_rst (
        .wf      (in_word[WF_W-1:0]),
        .kind    (kind),
        .invert  (invert),
        .xbit    (xbit),
        .payload (payload)
    );

    // Register the result. Reset or an empty cycle clears every output.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            out_data    <= 1'b0;
            out_ctrl    <= 1'b0;
            out_err     <= 1'b0;
            out_payload <= '0;
        end else begin
            out_valid   <= 1'b1;
            out_data    <= (kind == K_DATA);
            out_ctrl    <= (kind == K_CTRL);
            out_err     <= (kind == K_ERR);
            out_payload <= payload;
        end
    end

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_data, out_ctrl, out_err}) <= 1);

    // R8
    err_zero_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_payload == '0));

    // R4
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl |-> (out_payload[OUT_W-1:CTRL_W] == '0));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    empty_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_data && !out_ctrl && !out_err
                       && out_payload == '0));

    // R7
    narrow_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_mode) |=> !out_payload[OUT_W-1]);

    // R6
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-1:WF_W] == CF_CTL_T
         && in_word[HALF] == in_word[HALF-1])
        |=> (out_valid && !out_data && !out_ctrl && !out_err
             && out_payload == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_data && !out_ctrl && !out_err));
endmodule

// File: tb/sim_lcw_decoder.sv
module sim_lcw_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [19:0] in_word;
    logic        ext_mode;
    logic        out_valid, out_data, out_ctrl, out_err;
    logic [16:0] out_payload;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    lcw_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .ext_mode(ext_mode), .out_valid(out_valid), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_err(out_err), .out_payload(out_payload)
    );

    // Expected {data, ctrl, err, payload[16:0]} from the requirements.
    function automatic logic [19:0] model(input logic [19:0] w, input logic x);
        logic [15:0] f;
        f = w[15:0];
        case (w[19:16])
            4'b1101: return {3'b100, 1'b0, f};
            4'b0010: return {3'b100, 1'b0, ~f};
            4'b1011: return x ? {3'b100, 1'b1, f}  : {3'b001, 17'b0};
            4'b0100: return x ? {3'b100, 1'b1, ~f} : {3'b001, 17'b0};
            4'b0011, 4'b1100: begin
                if (w[19:16] == 4'b1100) f = ~f;
                if (w[7] != w[8]) return {3'b010, 3'b000, f[15:9], f[6:0]};
                return 20'b0;
            end
            default: return {3'b001, 17'b0};
        endcase
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [19:0] w, input logic x, input string tag);
        @(negedge clk);
        in_word  = w;
        ext_mode = x;
        in_valid = 1'b1;
        exp_q.push_back(model(w, x));
        tag_q.push_back(tag);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = 20'hFFFFF;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: pop the expected result whenever a result is strobed.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected result", 20'h1, 20'h0);
                end else begin
                    check(tag_q.pop_front(),
                          {out_data, out_ctrl, out_err, out_payload}, exp_q.pop_front());
                end
            end else begin
                check("R9 empty cycle", {out_data, out_ctrl, out_err, out_payload}, 20'h0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_word  = 20'hD1234;
        ext_mode = 1'b1;
        repeat (3) @(negedge clk);
        // R10: a valid word under reset leaves outputs cleared
        check("R10 reset state", {out_valid, out_data, out_ctrl, out_err, out_payload[15:0]}, 20'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        gap(2);

        send(20'hD_A5C3, 1'b0, "R2 true data");
        send(20'hD_0000, 1'b0, "R2 true data zero");
        send(20'h2_A5C3, 1'b0, "R3 inverted data");
        send(20'h2_FFFF, 1'b0, "R3 inverted data ones");
        send(20'h3_80FF, 1'b0, "R4 control");
        send(20'h3_0100, 1'b0, "R4 control w8");
        send(20'hC_7F7F, 1'b0, "R5 inverted control");
        send(20'hC_0080, 1'b0, "R5 inverted control w7");
        send(20'h3_0180, 1'b0, "R6 idle ones");
        send(20'hC_1234 & 20'hFFE7F, 1'b0, "R6 idle inverted");
        gap(1);
        send(20'hB_1357, 1'b1, "R7 ext true");
        send(20'h4_1357, 1'b1, "R7 ext inverted");
        send(20'hD_1357, 1'b1, "R7 ext plain true");
        send(20'h2_1357, 1'b1, "R7 ext plain inverted");
        send(20'hB_1357, 1'b0, "R8 ext code in narrow mode");
        send(20'h4_1357, 1'b0, "R8 ext inverted in narrow mode");
        send(20'h0_ABCD, 1'b0, "R8 illegal 0000");
        send(20'hF_ABCD, 1'b1, "R8 illegal 1111");
        send(20'h5_ABCD, 1'b0, "R8 illegal 0101");
        send(20'hA_ABCD, 1'b1, "R8 illegal 1010");
        gap(2);
        for (int k = 0; k < 200; k++) begin
            logic [19:0] w;
            logic        x;
            w = 20'($urandom);
            x = 1'($urandom);
            if (($urandom % 4) == 0) gap(1);
            send(w, x, "R1 random stream");
        end
        gap(3);
        check("R1 all results delivered", 20'(exp_q.size()), 20'h0);
        done = 1'b1;
        summary();
    end
endmodule